// File: doc/BRIEF.md
# Two-Channel Programmable Interval Timer

This block holds two independent 16-bit down-counters, called channel 0 and channel 2. Both advance only on cycles where an enable tick is high; the tick is expected at about 1.19318 MHz, so one count unit is one period of a 1193180 Hz clock. Software programs the block through a byte-wide write port. One address takes a control word that sets a channel's operating mode. Each channel has its own data address, and its count is loaded through that address as a low byte followed by a high byte. The second byte starts the count.

In mode 0 a channel runs once. When it expires it stops and, for channel 2, raises bit 5 of the status byte (value 0x20). In every other mode the channel reloads its programmed interval when it expires and keeps running.

Both channels share a single low/high sequencing flag. A low byte written to one channel and a high byte written to the other therefore load the second channel. Only the low-then-high access mode is accepted. A control word that asks for any other access mode, names a channel that does not exist, or asks for a read-back is refused and raises a one-cycle error pulse. A one-cycle expiry pulse per channel is also brought out so that each channel's timing can be observed.

Top module: `itv_timer`

## Requirements
- R1: After reset the status byte is 0x00, no expiry pulse or error pulse is high, both channels are idle and the low/high sequencing flag is clear, so the next data write is taken as a low byte.
- R2: Data writes go to address 0 (channel 0) or address 1 (channel 2). The first write stores the low byte and counts nothing. The second write forms the count as high byte × 256 + low byte and starts the channel. A channel loaded with N expires on the N-th tick after the write.
- R3: The low/high flag is shared by both channels. The channel addressed by the second (high) byte is the one that loads, using the low byte stored from whichever channel was written first.
- R4: A control word is written to address 2. Bits 7:6 = 00 select channel 0 and 10 select channel 2. The value 11 (read-back) and the value 01 are refused: the mode is left unchanged and the error output is high for one cycle after the write.
- R5: Control bits 5:4 must be 11. Any other value is refused in the same way as R4: the mode is left unchanged and a one-cycle error pulse is raised.
- R6: Control bits 3:1 give the mode. A channel in mode 0 stops after its single expiry, and for channel 2 the status byte becomes 0x20.
- R7: In any mode other than 0, a channel loaded with N expires again every N ticks, indefinitely.
- R8: Completing a load (the second byte) on channel 2 clears the status byte to 0x00 in the same cycle as the write.
- R9: A count of 0 is treated as 65536 ticks.
- R10: Counters change only on cycles where tick is high. Cycles without a tick leave the remaining count unchanged.
- R11: A write to address 3 has no effect. In particular it does not take part in the low/high sequencing.
- R12: expire_o[0] (channel 0) and expire_o[1] (channel 2) pulse high for exactly one cycle at each expiry. The status output always reflects channel 2 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one cycle per timer period |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | 0: channel 0 data, 1: channel 2 data, 2: control word, 3: unused |
| wr_data | input | 8 | Write byte |
| status_o | output | 8 | Channel 2 status (0x20 after a mode-0 expiry, otherwise 0x00) |
| expire_o | output | 2 | Per-channel one-cycle expiry pulse (bit 0: channel 0, bit 1: channel 2) |
| err_o | output | 1 | One-cycle pulse after a refused control word |

## Verification
A completing data write takes effect at the clock edge that captures it, so the count starts right after that edge. With a count of N, the expiry pulse and the 0x20 status appear after the N-th tick edge and are sampled at the falling edge that follows. The error pulse is registered, so it is due one cycle after the control write. The bench drives every input at a falling edge and reads outputs at the next falling edge, which places each check exactly one register stage after its cause. Checks that expect no expiry are taken at every tick before the due one, so an early or late expiry cannot pass unnoticed.

// File: rtl/itv_pkg.sv
package itv_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int SPAN_W = CNT_W + 1;
  localparam int NCH    = 2;
  localparam int MODE_W = 3;

  localparam logic [1:0] ADR_DATA_A = 2'd0;
  localparam logic [1:0] ADR_DATA_B = 2'd1;
  localparam logic [1:0] ADR_CTRL   = 2'd2;

  localparam logic [BYTE_W-1:0] STAT_DONE = 8'h20;

  typedef struct packed {
    logic              ok;
    logic              slot;
    logic [MODE_W-1:0] mode;
  } ctrl_dec_t;

  // Join two bytes into a count.
  function automatic logic [CNT_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  // Map a count to its tick span; zero means the full range.
  function automatic logic [SPAN_W-1:0] span_of(input logic [CNT_W-1:0] v);
    if (v == '0) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, v};
  endfunction

  // Decode a control word.
  function automatic ctrl_dec_t decode_ctrl(input logic [BYTE_W-1:0] w);
    ctrl_dec_t d;
    d.mode = w[3:1];
    d.slot = w[7];
    d.ok   = (w[5:4] == 2'b11) && (w[6] == 1'b0);
    return d;
  endfunction
endpackage

// File: rtl/itv_loader.sv
module itv_loader
  import itv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    data_we,
  input  logic [BYTE_W-1:0] data_byte,
  output logic [NCH-1:0]    load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic              pend_o
);
  logic              pend_q;
  logic [BYTE_W-1:0] lo_q;
  logic              any_we;

  assign any_we   = |data_we;
  assign load_stb = pend_q ? data_we : '0;
  assign load_val = join_bytes(data_byte, lo_q);
  assign pend_o   = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lo_q   <= '0;
    end else if (any_we) begin
      pend_q <= ~pend_q;
      if (!pend_q) lo_q <= data_byte;
    end
  end

  // R2
  pend_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_we |=> (pend_q != $past(pend_q)));
  // R3
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));
endmodule

// File: rtl/itv_ctrl_dec.sv
module itv_ctrl_dec
  import itv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [BYTE_W-1:0] ctrl_byte,
  output logic [NCH-1:0]    mode_we,
  output logic [MODE_W-1:0] mode_val,
  output logic              err_o
);
  ctrl_dec_t dec;
  logic      err_q;

  assign dec      = decode_ctrl(ctrl_byte);
  assign mode_val = dec.mode;
  assign err_o    = err_q;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_sel
      assign mode_we[g] = ctrl_we && dec.ok && (dec.slot == g[0]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= ctrl_we && !dec.ok;
  end

  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(ctrl_we));
  // R5
  refused_no_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_byte[5:4] != 2'b11) |-> (mode_we == '0));
endmodule

// File: rtl/itv_channel.sv
module itv_channel
  import itv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_in,
  output logic [BYTE_W-1:0] status,
  output logic              expire
);
  logic [SPAN_W-1:0] cnt_q, ival_q;
  logic [MODE_W-1:0] mode_q;
  logic              run_q, exp_q;
  logic [BYTE_W-1:0] stat_q;
  logic              term_evt;

  // Named event: the running counter reaches its end on this tick.
  assign term_evt = run_q && tick && (cnt_q == SPAN_W'(1)) && !load;
  assign status   = stat_q;
  assign expire   = exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q <= mode_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ival_q <= '0;
      run_q  <= 1'b0;
      exp_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      exp_q <= term_evt;
      if (load) begin
        cnt_q  <= span_of(load_val);
        ival_q <= span_of(load_val);
        run_q  <= 1'b1;
        stat_q <= '0;
      end else if (term_evt) begin
        if (mode_q == '0) begin
          run_q  <= 1'b0;
          stat_q <= STAT_DONE;
        end else begin
          cnt_q <= ival_q;
        end
      end else if (run_q && tick) begin
        cnt_q <= cnt_q - SPAN_W'(1);
      end
    end
  end

  // R8
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (stat_q == '0 && run_q));
  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && mode_q == '0) |=> (!run_q && stat_q == STAT_DONE && exp_q));
  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && mode_q != '0) |=> (run_q && cnt_q == ival_q && exp_q));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  // R12
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q && ival_q != SPAN_W'(1)) |=> !exp_q);
endmodule

// File: rtl/itv_timer.sv
module itv_timer
  import itv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] status_o,
  output logic [NCH-1:0]    expire_o,
  output logic              err_o
);
  logic [NCH-1:0]    data_we, load_stb, mode_we;
  logic [CNT_W-1:0]  load_val;
  logic [MODE_W-1:0] mode_val;
  logic              ctrl_we, pend;
  logic [BYTE_W-1:0] stat_w [NCH];

  assign data_we[0] = wr_en && (wr_addr == ADR_DATA_A);
  assign data_we[1] = wr_en && (wr_addr == ADR_DATA_B);
  assign ctrl_we    = wr_en && (wr_addr == ADR_CTRL);

  itv_loader u_load (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_byte(wr_data),
    .load_stb(load_stb), .load_val(load_val), .pend_o(pend)
  );

  itv_ctrl_dec u_dec (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_byte(wr_data),
    .mode_we(mode_we), .mode_val(mode_val), .err_o(err_o)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      itv_channel u_ch (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(load_stb[c]), .load_val(load_val),
        .mode_we(mode_we[c]), .mode_in(mode_val),
        .status(stat_w[c]), .expire(expire_o[c])
      );
    end
  endgenerate

  assign status_o = stat_w[NCH-1];

  // R11
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> (pend == $past(pend)));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (status_o == '0 && expire_o == '0 && !err_o && !pend));
endmodule

// File: tb/itv_timer_test.sv
module itv_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] status_o;
  logic [1:0] expire_o;
  logic       err_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  itv_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .status_o(status_o), .expire_o(expire_o), .err_o(err_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycles %0d expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic t);
    tick = t;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(0); step(0);
    rst_n = 1'b1;
  endtask

  // Tick n times; expect the channel's pulse only on the last tick.
  task automatic expect_after(string req, int ch, int n);
    bit early = 0;
    for (int i = 1; i < n; i++) begin
      step(1);
      if (expire_o[ch]) early = 1;
    end
    check({req, " no early expiry"}, early, 0);
    step(1);
    check({req, " expiry on tick N"}, expire_o[ch], 1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 status", status_o, 8'h00);
    check("R1 expire", expire_o, 2'b00);
    check("R1 err", err_o, 0);
    // First data write after reset is a low byte: 2 then 0 -> 2 ticks.
    wr(2'd2, 8'hB0);
    wr(2'd1, 8'h02); wr(2'd1, 8'h00);
    expect_after("R1 low byte first", 1, 2);
  endtask

  task automatic t_oneshot();
    do_reset();
    wr(2'd2, 8'hB0);
    wr(2'd1, 8'h03);
    step(1); step(1);
    check("R2 no count after low byte", expire_o, 2'b00);
    wr(2'd1, 8'h01);
    check("R8 status cleared at load", status_o, 8'h00);
    expect_after("R2 259 ticks", 1, 259);
    check("R6 status done", status_o, 8'h20);
    check("R12 ch0 quiet", expire_o[0], 0);
    step(1);
    check("R12 one-cycle pulse", expire_o[1], 0);
    begin
      bit again = 0;
      for (int i = 0; i < 20; i++) begin step(1); if (expire_o[1]) again = 1; end
      check("R6 stopped after expiry", again, 0);
    end
    check("R6 status holds", status_o, 8'h20);
    wr(2'd1, 8'h02);
    check("R2 low byte keeps status", status_o, 8'h20);
    wr(2'd1, 8'h00);
    check("R8 reload clears status", status_o, 8'h00);
  endtask

  task automatic t_shared();
    do_reset();
    wr(2'd2, 8'hB0);
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h00);
    expect_after("R3 cross-channel load", 1, 4);
    check("R3 ch0 not started", expire_o[0], 0);
  endtask

  task automatic t_periodic_and_ctrl();
    do_reset();
    wr(2'd2, 8'h34);
    step(0);
    check("R4 good ctrl no err", err_o, 0);
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    expect_after("R7 period 1", 0, 3);
    expect_after("R7 period 2", 0, 3);
    wr(2'd2, 8'hF0);
    check("R4 read-back err", err_o, 1);
    step(0);
    check("R4 err one cycle", err_o, 0);
    wr(2'd2, 8'h70);
    check("R4 channel 1 err", err_o, 1);
    wr(2'd2, 8'h20);
    check("R5 bad access err", err_o, 1);
    expect_after("R5 mode unchanged", 0, 3);
    expect_after("R7 period 4", 0, 3);
    check("R12 status only ch2", status_o, 8'h00);
    wr(2'd2, 8'h30);
    check("R6 ch0 mode0 accepted", err_o, 0);
    expect_after("R6 ch0 last expiry", 0, 3);
    begin
      bit again = 0;
      for (int i = 0; i < 8; i++) begin step(1); if (expire_o[0]) again = 1; end
      check("R6 ch0 stopped", again, 0);
    end
  endtask

  task automatic t_gating();
    do_reset();
    wr(2'd2, 8'hB0);
    wr(2'd1, 8'h03); wr(2'd1, 8'h00);
    step(1); step(1);
    for (int i = 0; i < 6; i++) step(0);
    check("R10 held without tick", expire_o[1], 0);
    step(1);
    check("R10 expiry on third tick", expire_o[1], 1);
  endtask

  task automatic t_unused();
    do_reset();
    wr(2'd2, 8'hB0);
    wr(2'd0, 8'h07);
    wr(2'd3, 8'h55);
    wr(2'd1, 8'h00);
    expect_after("R11 unused address ignored", 1, 7);
  endtask

  task automatic t_zero();
    do_reset();
    wr(2'd2, 8'hB0);
    wr(2'd1, 8'h00); wr(2'd1, 8'h00);
    expect_after("R9 zero is 65536", 1, 65536);
    check("R9 status done", status_o, 8'h20);
  endtask

  initial begin
    t_reset();
    t_oneshot();
    t_shared();
    t_periodic_and_ctrl();
    t_gating();
    t_unused();
    t_zero();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule